// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a chain of four-bit synchronous up-counting stages. All stages share one clock, one active-low asynchronous clear, one active-low synchronous load and one parallel count enable. Each stage produces a terminal-count signal. That signal is high only when the stage's trickle enable is high and the stage holds all ones. It feeds the trickle enable of the next stage, so the chain behaves as one wide binary counter with no ripple through the registers.

The first stage's trickle enable comes from a pin. The last stage's terminal count goes out as a pin, so chains can in turn be cascaded. The load copies the full-width data input into every stage on one edge. The clear zeroes every stage at once, without a clock. The block has no data stream: every pin is a plain control or status level, and there is no handshake or back-pressure.

Top module: `casc_counter`

## Requirements
- R1: With ld_n high and both en_par and en_trk high, q advances by one on each rising clk edge as one plain binary number of STAGES*STAGE_W bits, with stage 0 in the low bits.
- R2: From the all-ones value, a counting edge gives zero in every stage.
- R3: While clr_n is low, q is zero immediately, without a clock edge. The clock, load and enables have no effect until clr_n returns high.
- R4: With ld_n low, q takes din on the next rising clk edge, whatever en_par and en_trk are.
- R5: With ld_n high and either en_par or en_trk low, q keeps its value across clk edges.
- R6: tc_out is combinational. It is 1 exactly when en_trk is 1 and every bit of q is 1, and it changes with en_trk without any clock edge.
- R7: A stage above stage 0 changes on a counting edge only when every lower stage held all ones before that edge (carry across stage boundaries).
- R8: The load and the clear act on all stages together on the same edge or instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all stages |
| clr_n | input | 1 | Active-low asynchronous clear |
| ld_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable of stage 0 |
| din | input | STAGES*STAGE_W | Load value, stage 0 in the low bits |
| q | output | STAGES*STAGE_W | Count value, stage 0 in the low bits |
| tc_out | output | 1 | Terminal count of the last stage |

## Verification
The hardest case to reach from the pins is a carry that must pass through every stage on a single edge. That happens only from the all-ones value, and counting up from zero would take thousands of cycles to get there. The stimulus reaches it by loading values just below the stage boundaries (0x00E, 0xFFD) with both enables high, then counting across them. A clear is also dropped halfway between edges, with load and enables asserted, and held across an edge to show that it overrides them. An integer model paces a long run in which both enables are switched at random.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int DEF_STAGE_W = 4;
  localparam int DEF_STAGES  = 3;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int W = DEF_STAGE_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] d,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_op_e op;

  // load outranks both enables
  always_comb begin
    if (!ld_n)              op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = d;
      OP_COUNT: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = DEF_STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] nxt;

  cnt_next #(.W(W)) u_next (
    .cur (q),
    .d   (d),
    .ld_n(ld_n),
    .en_p(en_p),
    .en_t(en_t),
    .nxt (nxt)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  assign tc = en_t & (q == ONES);

  // R3
  clr_zero_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(d));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && en_t) |=> q == W'($past(q) + ONE));
  // R5
  hold_still_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));
  // R6
  tc_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> (en_t && q == ONES));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int STAGES  = DEF_STAGES,
  parameter int STAGE_W = DEF_STAGE_W
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      ld_n,
  input  logic                      en_par,
  input  logic                      en_trk,
  input  logic [STAGES*STAGE_W-1:0] din,
  output logic [STAGES*STAGE_W-1:0] q,
  output logic                      tc_out
);
  localparam int TW = STAGES * STAGE_W;
  localparam logic [STAGE_W-1:0] ONES = {STAGE_W{1'b1}};

  logic [STAGES:0] trk;
  logic [STAGE_W-1:0] sq [STAGES];

  assign trk[0] = en_trk;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk  (clk),
      .clr_n(clr_n),
      .ld_n (ld_n),
      .en_p (en_par),
      .en_t (trk[k]),
      .d    (din[k*STAGE_W +: STAGE_W]),
      .q    (sq[k]),
      .tc   (trk[k+1])
    );
    assign q[k*STAGE_W +: STAGE_W] = sq[k];

    if (k > 0) begin : g_carry
      // R7
      carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(ld_n) && sq[k] != $past(sq[k])) |-> $past(sq[k-1]) == ONES);
    end
  end

  assign tc_out = trk[STAGES];

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_par && en_trk && q == {TW{1'b1}}) |=> q == '0);
endmodule

// File: tb/test_casc_counter.sv
module test_casc_counter;
  localparam int NS = 3;
  localparam int SW = 4;
  localparam int TW = NS * SW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clr_n = 1'b1, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] q;
  logic tc;

  int errors = 0;
  int checks = 0;
  logic [TW-1:0] model = '0;
  logic [TW:0] exp_q[$];
  string tag_q[$];
  logic [TW:0] e_item;
  string e_tag;

  casc_counter #(.STAGES(NS), .STAGE_W(SW)) i_casc_counter (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(ep), .en_trk(et),
    .din(din), .q(q), .tc_out(tc)
  );

  task automatic chk(input bit ok, input string req, input logic [TW:0] act,
                     input logic [TW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply inputs, push the value expected after the next edge
  task automatic step(input bit l, input logic [TW-1:0] d, input bit p,
                      input bit t, input string req);
    @(negedge clk);
    ld_n = l; din = d; ep = p; et = t;
    if (!l) model = d;
    else if (p && t) model = model + 1'b1;
    exp_q.push_back({t && (model == {TW{1'b1}}), model});
    tag_q.push_back(req);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      e_item = exp_q.pop_front();
      e_tag  = tag_q.pop_front();
      chk({tc, q} === e_item, e_tag, {tc, q}, e_item);
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 clr_n = 1'b0;
    #2 chk({tc, q} === '0, "R3", {tc, q}, '0);
    @(negedge clk) clr_n = 1'b1;

    // load with enables high, then carry over the first stage boundary
    step(1'b0, 12'h00E, 1'b1, 1'b1, "R4");
    step(1'b1, '0, 1'b1, 1'b1, "R1");
    step(1'b1, '0, 1'b1, 1'b1, "R7");
    step(1'b1, '0, 1'b1, 1'b1, "R1");
    // full-width load, then carry through all stages and wrap
    step(1'b0, 12'hFFD, 1'b1, 1'b1, "R8");
    step(1'b1, '0, 1'b1, 1'b1, "R1");
    step(1'b1, '0, 1'b1, 1'b1, "R6");
    step(1'b1, '0, 1'b1, 1'b1, "R2");
    step(1'b1, '0, 1'b1, 1'b1, "R1");
    // 0x0FF -> 0x100 crosses two boundaries
    step(1'b0, 12'h0FF, 1'b0, 1'b1, "R4");
    step(1'b1, '0, 1'b1, 1'b1, "R7");
    // holds
    step(1'b1, '0, 1'b0, 1'b1, "R5");
    step(1'b1, '0, 1'b1, 1'b0, "R5");
    step(1'b1, '0, 1'b0, 1'b0, "R5");
    // load with both enables low, all ones, trickle low => tc low
    step(1'b0, 12'hFFF, 1'b0, 1'b0, "R4");
    @(negedge clk);
    ld_n = 1'b1; ep = 1'b0; et = 1'b1;
    #1 chk(tc === 1'b1, "R6", {12'h000, tc}, {12'h000, 1'b1});
    et = 1'b0;
    #1 chk(tc === 1'b0, "R6", {12'h000, tc}, '0);
    step(1'b1, '0, 1'b1, 1'b0, "R5");

    // clear between edges, overriding load and enables
    @(negedge clk);
    #1 clr_n = 1'b0; ld_n = 1'b0; din = 12'hA5C; ep = 1'b1; et = 1'b1;
    #0.5 chk(q === '0, "R3", {1'b0, q}, '0);
    @(posedge clk);
    #1 chk({tc, q} === '0, "R3", {tc, q}, '0);
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b1; ep = 1'b0; et = 1'b0;
    model = '0;
    step(1'b1, '0, 1'b1, 1'b1, "R3");

    // long run with random enables and occasional loads
    for (int i = 0; i < 400; i++) begin
      bit p = ($urandom % 4) != 0;
      bit t = ($urandom % 6) != 0;
      if (($urandom % 40) == 0)
        step(1'b0, 12'($urandom), p, t, "R4");
      else if (p && t)
        step(1'b1, '0, p, t, "R1");
      else
        step(1'b1, '0, p, t, "R5");
    end

    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule